// File: doc/BRIEF.md
# Fuse Packet Programmer with Read-Back Verify

This block writes one configuration packet into a one-time-programmable byte array, starting at an address the host supplies. A packet has a 7-bit section number, a 4-bit active-low word-enable mask (a 0 bit selects a word) and eight data bytes that form four 16-bit words. The block first writes a header that encodes the section and the mask. That header is one byte for low section numbers and two bytes for high ones. It then writes only the selected data words, in the bytes directly after the header.

Each byte is handled in three steps: a write strobe, a read strobe at the same address, and a compare in the following cycle. A header byte that still reads back as erased (0xFF) is written again, up to a retry budget that both header bytes share. A header byte that reads back with any other wrong value ends the packet at once. Data bytes are not retried. Instead, the block reports each data word whose read-back disagrees in a failure mask, and the host decides whether to relocate that word.

The array sits outside the block. Its write takes effect at the clock edge that samples the write strobe. Its read data is registered and is valid in the cycle after the read strobe.

Top module: `fuse_pkt_prog`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `done`, `fz_wr` and `fz_rd` are all 0.
- R2: A section below 16 produces a single header byte equal to {section[3:0], mask}, written at `start_addr`.
- R3: A section of 16 or more produces two header bytes at `start_addr` and `start_addr`+1. The first is {section[2:0], 5'b01111} and the second is {section[6:3], mask}.
- R4: Every byte attempt takes three cycles: `fz_wr` for one cycle, then `fz_rd` at an unchanged address, then one compare cycle with neither strobe.
- R5: A header byte that reads back as 0xFF is rewritten. The packet allows RETRY_MAX rewrites in total across both header bytes. One more 0xFF read-back ends the packet with `ok`=0 and `bad_words`=4'hF, and no data byte is written.
- R6: A header read-back that is neither 0xFF nor the intended byte ends the packet immediately with `ok`=0 and `bad_words`=4'hF, and no data byte is written.
- R7: Selected words are written in ascending order (word 0 to word 3) at consecutive addresses after the header, and unselected words are skipped. Word w occupies data bytes 2w then 2w+1, where byte i is `data[8i+7:8i]`.
- R8: `bad_words` starts at 4'hF. Bit w is cleared when either byte of word w reads back differently from the byte written. Data bytes are not retried, and `ok`=1 whenever the header succeeded.
- R9: `next_addr` equals `start_addr` plus the header length (1 or 2) plus twice the number of zero bits in the mask, modulo 2^ADDR_W.
- R10: `busy` rises in the cycle after an accepted `start` and stays high through the single cycle in which `done` is high. It falls in the next cycle, and `ok`, `bad_words` and `next_addr` are valid while `done` is high.
- R11: A `start` pulse while `busy` is high is ignored, along with the inputs presented with it.
- R12: A mask of 4'hF writes only the header. On header success it ends with `ok`=1 and `bad_words`=4'hF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, sampled while idle |
| start_addr | input | ADDR_W | First byte address of the packet |
| section | input | 7 | Section number |
| word_en_n | input | 4 | Active-low word select |
| data | input | 64 | Eight data bytes, byte i at bits 8i+7:8i |
| busy | output | 1 | Packet in progress |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Header programmed successfully |
| bad_words | output | 4 | Active-low failed-word mask |
| next_addr | output | ADDR_W | Address following the packet |
| fz_wr | output | 1 | Array byte write strobe |
| fz_rd | output | 1 | Array byte read strobe |
| fz_addr | output | ADDR_W | Array byte address |
| fz_wdata | output | 8 | Array write byte |
| fz_rdata | input | 8 | Array read byte, valid the cycle after `fz_rd` |

## Verification
The time to finish is fully set by the number of byte attempts. With A attempts (retries included), `busy` is high for 3A+1 cycles after the edge that accepts `start`, and `done` is high in the last of those cycles. The bench model replays the packet against a copy of the array contents and the injected faults to find A. It then compares `busy` and `done` at every falling edge in that window and one cycle past it. It reads `ok`, `bad_words` and `next_addr` in the `done` cycle, and compares the array bytes after the packet ends.

// File: rtl/fz_pkg.sv
package fz_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR,
        ST_RD,
        ST_CHK,
        ST_DONE
    } fz_state_e;

    typedef enum logic {
        PH_HDR,
        PH_DATA
    } fz_phase_e;

    typedef struct packed {
        logic       two;
        logic [7:0] b0;
        logic [7:0] b1;
    } fz_hdr_t;

    function automatic logic [2:0] zero_count(input logic [3:0] m);
        logic [2:0] n;
        n = 3'd0;
        for (int i = 0; i < 4; i++)
            if (!m[i]) n = n + 3'd1;
        return n;
    endfunction

    function automatic fz_hdr_t build_hdr(input logic [6:0] sec, input logic [3:0] m);
        fz_hdr_t h;
        if (sec[6:4] != 3'd0) begin
            h.two = 1'b1;
            h.b0  = {sec[2:0], 5'b01111};
            h.b1  = {sec[6:3], m};
        end else begin
            h.two = 1'b0;
            h.b0  = {sec[3:0], m};
            h.b1  = 8'hFF;
        end
        return h;
    endfunction

endpackage

// File: rtl/fz_hdr_gen.sv
module fz_hdr_gen
    import fz_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic [6:0]        sec,
    input  logic [3:0]        mask_n,
    input  logic [ADDR_W-1:0] base,
    output fz_hdr_t           hdr,
    output logic [ADDR_W-1:0] after
);
    logic [2:0] nwords;

    always_comb begin
        hdr    = build_hdr(sec, mask_n);
        nwords = zero_count(mask_n);
        after  = base + ADDR_W'(hdr.two ? 2 : 1) + ADDR_W'({nwords, 1'b0});
    end
endmodule

// File: rtl/fz_word_pick.sv
module fz_word_pick (
    input  logic [3:0] mask_n,
    input  logic [2:0] from,
    output logic       found,
    output logic [1:0] idx
);
    logic [3:0] cand;

    for (genvar w = 0; w < 4; w++) begin : g_cand
        assign cand[w] = !mask_n[w] && (3'(w) >= from);
    end

    always_comb begin
        found = |cand;
        idx   = 2'd0;
        for (int w = 3; w >= 0; w--)
            if (cand[w]) idx = 2'(w);
    end
endmodule

// File: rtl/fz_retry_ctr.sv
module fz_retry_ctr #(
    parameter int RETRY_MAX = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);
    localparam int RC_W = $clog2(RETRY_MAX + 2);

    logic [RC_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (inc)
            cnt <= cnt + RC_W'(1);
    end

    assign at_limit = (cnt == RC_W'(RETRY_MAX));
endmodule

// File: rtl/fuse_pkt_prog.sv
module fuse_pkt_prog
    import fz_pkg::*;
#(
    parameter int ADDR_W    = 9,
    parameter int RETRY_MAX = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [6:0]        section,
    input  logic [3:0]        word_en_n,
    input  logic [63:0]       data,
    output logic              busy,
    output logic              done,
    output logic              ok,
    output logic [3:0]        bad_words,
    output logic [ADDR_W-1:0] next_addr,
    output logic              fz_wr,
    output logic              fz_rd,
    output logic [ADDR_W-1:0] fz_addr,
    output logic [7:0]        fz_wdata,
    input  logic [7:0]        fz_rdata
);
    fz_state_e         st;
    fz_phase_e         ph;
    logic [ADDR_W-1:0] addr_q, next_q, next_new;
    logic              hsel, bsel, ok_q;
    logic [1:0]        wsel;
    logic [3:0]        mask_q, bad_q;
    logic [63:0]       data_q;
    fz_hdr_t           hdr_q, hdr_new;
    logic [7:0]        cur_byte;
    logic [2:0]        pick_from;
    logic              pick_found, at_limit, accept, rd_erased, retry_inc;
    logic [1:0]        pick_idx;

    fz_hdr_gen #(.ADDR_W(ADDR_W)) u_hdr (
        .sec(section), .mask_n(word_en_n), .base(start_addr),
        .hdr(hdr_new), .after(next_new)
    );

    assign pick_from = (ph == PH_HDR) ? 3'd0 : ({1'b0, wsel} + 3'd1);

    fz_word_pick u_pick (
        .mask_n(mask_q), .from(pick_from), .found(pick_found), .idx(pick_idx)
    );

    assign accept    = (st == ST_IDLE) && start;
    assign rd_erased = (fz_rdata == 8'hFF);
    assign retry_inc = (st == ST_CHK) && (ph == PH_HDR) && rd_erased && !at_limit;

    fz_retry_ctr #(.RETRY_MAX(RETRY_MAX)) u_retry (
        .clk(clk), .rst(rst), .clr(accept), .inc(retry_inc), .at_limit(at_limit)
    );

    always_comb begin
        if (ph == PH_HDR)
            cur_byte = hsel ? hdr_q.b1 : hdr_q.b0;
        else
            cur_byte = data_q[{wsel, bsel, 3'b000} +: 8];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            ph     <= PH_HDR;
            addr_q <= '0;
            next_q <= '0;
            hsel   <= 1'b0;
            bsel   <= 1'b0;
            wsel   <= 2'd0;
            mask_q <= 4'hF;
            data_q <= '0;
            hdr_q  <= '0;
            ok_q   <= 1'b0;
            bad_q  <= 4'hF;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        addr_q <= start_addr;
                        next_q <= next_new;
                        hdr_q  <= hdr_new;
                        mask_q <= word_en_n;
                        data_q <= data;
                        ph     <= PH_HDR;
                        hsel   <= 1'b0;
                        ok_q   <= 1'b0;
                        bad_q  <= 4'hF;
                        st     <= ST_WR;
                    end
                end
                ST_WR: st <= ST_RD;
                ST_RD: st <= ST_CHK;
                ST_CHK: begin
                    if (ph == PH_HDR) begin
                        if (rd_erased) begin
                            st <= at_limit ? ST_DONE : ST_WR;
                        end else if (fz_rdata != cur_byte) begin
                            st <= ST_DONE;
                        end else begin
                            addr_q <= addr_q + ADDR_W'(1);
                            if (hdr_q.two && !hsel) begin
                                hsel <= 1'b1;
                                st   <= ST_WR;
                            end else if (pick_found) begin
                                ph   <= PH_DATA;
                                wsel <= pick_idx;
                                bsel <= 1'b0;
                                st   <= ST_WR;
                            end else begin
                                ok_q <= 1'b1;
                                st   <= ST_DONE;
                            end
                        end
                    end else begin
                        if (fz_rdata != cur_byte) bad_q[wsel] <= 1'b0;
                        addr_q <= addr_q + ADDR_W'(1);
                        if (!bsel) begin
                            bsel <= 1'b1;
                            st   <= ST_WR;
                        end else if (pick_found) begin
                            wsel <= pick_idx;
                            bsel <= 1'b0;
                            st   <= ST_WR;
                        end else begin
                            ok_q <= 1'b1;
                            st   <= ST_DONE;
                        end
                    end
                end
                ST_DONE: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (st != ST_IDLE);
    assign done      = (st == ST_DONE);
    assign fz_wr     = (st == ST_WR);
    assign fz_rd     = (st == ST_RD);
    assign fz_addr   = addr_q;
    assign fz_wdata  = cur_byte;
    assign ok        = ok_q;
    assign bad_words = bad_q;
    assign next_addr = next_q;
endmodule

// File: rtl/fuse_pkt_prog_chk.sv
module fuse_pkt_prog_chk #(
    parameter int ADDR_W = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              ok,
    input logic [3:0]        bad_words,
    input logic              fz_wr,
    input logic              fz_rd,
    input logic [ADDR_W-1:0] fz_addr
);
    // R4
    wr_then_rd_chk: assert property (@(posedge clk) disable iff (rst)
        fz_wr |=> fz_rd && $stable(fz_addr));
    // R4
    rd_then_cmp_chk: assert property (@(posedge clk) disable iff (rst)
        fz_rd |=> !fz_wr && !fz_rd);
    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(fz_wr && fz_rd));
    // R10
    done_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);
    // R10
    done_ends_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy && !done);
    // R10
    start_takes_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> busy);
    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !fz_wr && !fz_rd);
    // R5
    fail_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !ok) |-> bad_words == 4'hF);
endmodule

bind fuse_pkt_prog fuse_pkt_prog_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .ok(ok),
    .bad_words(bad_words), .fz_wr(fz_wr), .fz_rd(fz_rd), .fz_addr(fz_addr)
);

// File: tb/test_fuse_pkt_prog.sv
module test_fuse_pkt_prog;
    localparam int AW   = 9;
    localparam int RMAX = 3;
    localparam int NB   = 512;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [6:0]    section = '0;
    logic [3:0]    word_en_n = 4'hF;
    logic [63:0]   data = '0;
    logic          busy, done, ok, fz_wr, fz_rd;
    logic [3:0]    bad_words;
    logic [AW-1:0] next_addr, fz_addr;
    logic [7:0]    fz_wdata;
    logic [7:0]    fz_rdata = 8'hFF;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;

    logic [7:0] fmem [NB];
    int         fdrop [NB];
    logic [7:0] pm [NB];
    int         pd [NB];

    int         e_ok, e_n;
    logic [3:0] e_bad;
    int         e_next;

    fuse_pkt_prog #(.ADDR_W(AW), .RETRY_MAX(RMAX)) i_fuse_pkt_prog (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
        .section(section), .word_en_n(word_en_n), .data(data),
        .busy(busy), .done(done), .ok(ok), .bad_words(bad_words),
        .next_addr(next_addr), .fz_wr(fz_wr), .fz_rd(fz_rd),
        .fz_addr(fz_addr), .fz_wdata(fz_wdata), .fz_rdata(fz_rdata)
    );

    always #2.5 clk = ~clk;

    // array model: writes clear bits unless a dropped write is pending
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (fz_wr) begin
            if (fdrop[fz_addr] > 0) fdrop[fz_addr] = fdrop[fz_addr] - 1;
            else fmem[fz_addr] = fmem[fz_addr] & fz_wdata;
        end
        if (fz_rd) fz_rdata <= fmem[fz_addr];
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            mismatched++;
            $display("FAIL watchdog: act=hung exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic chk(input bit good, input string tag, input longint act, input longint exp);
        compared++;
        if (!good) begin
            mismatched++;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_array();
        for (int i = 0; i < NB; i++) begin
            fmem[i] = 8'hFF;
            fdrop[i] = 0;
        end
    endtask

    task automatic mwr(input int a, input logic [7:0] v);
        if (pd[a] > 0) pd[a] = pd[a] - 1;
        else pm[a] = pm[a] & v;
    endtask

    task automatic predict(input int sa, input logic [6:0] sec, input logic [3:0] m,
                           input logic [63:0] d);
        logic [7:0] hb [2];
        int nh, ops, rc, a, zc;
        bit fail, fin;
        logic [7:0] by;
        for (int i = 0; i < NB; i++) begin
            pm[i] = fmem[i];
            pd[i] = fdrop[i];
        end
        if (sec >= 16) begin
            nh = 2;
            hb[0] = {sec[2:0], 5'b01111};
            hb[1] = {sec[6:3], m};
        end else begin
            nh = 1;
            hb[0] = {sec[3:0], m};
            hb[1] = 8'hFF;
        end
        ops = 0; rc = 0; a = sa; fail = 0; e_bad = 4'hF;
        for (int h = 0; h < nh && !fail; h++) begin
            fin = 0;
            while (!fin) begin
                ops++;
                mwr(a, hb[h]);
                if (pm[a] == 8'hFF) begin
                    if (rc == RMAX) begin fail = 1; fin = 1; end
                    else rc++;
                end else if (pm[a] != hb[h]) begin
                    fail = 1; fin = 1;
                end else begin
                    a++; fin = 1;
                end
            end
        end
        if (!fail) begin
            for (int w = 0; w < 4; w++) begin
                if (!m[w]) begin
                    for (int b = 0; b < 2; b++) begin
                        by = d[(2*w+b)*8 +: 8];
                        ops++;
                        mwr(a, by);
                        if (pm[a] != by) e_bad[w] = 1'b0;
                        a++;
                    end
                end
            end
        end
        zc = 0;
        for (int w = 0; w < 4; w++) if (!m[w]) zc++;
        e_ok = fail ? 0 : 1;
        e_next = (sa + nh + 2 * zc) % NB;
        e_n = 3 * ops + 1;
    endtask

    task automatic run(input string tag, input int sa, input logic [6:0] sec,
                       input logic [3:0] m, input logic [63:0] d, input int poke);
        predict(sa, sec, m, d);
        @(negedge clk);
        start = 1'b1; start_addr = AW'(sa); section = sec; word_en_n = m; data = d;
        for (int i = 1; i <= e_n + 1; i++) begin
            @(negedge clk);
            if (i == 1) start = 1'b0;
            if (poke > 0 && i == poke) begin
                // R11: request during busy must change nothing
                start = 1'b1; start_addr = AW'(sa + 200); section = 7'h33;
                word_en_n = 4'h0; data = ~d;
            end
            if (poke > 0 && i == poke + 1) start = 1'b0;
            // R10: busy window and done pulse per cycle
            chk(busy == (i <= e_n), {tag, " R10 busy"}, busy, (i <= e_n));
            chk(done == (i == e_n), {tag, " R10 done"}, done, (i == e_n));
            if (i == e_n) begin
                chk(ok == e_ok[0], {tag, " R5/R6/R8 ok"}, ok, e_ok);
                chk(bad_words == e_bad, {tag, " R8 bad_words"}, bad_words, e_bad);
                chk(int'(next_addr) == e_next, {tag, " R9 next_addr"}, next_addr, e_next);
            end
        end
        // R2 R3 R7: array contents after the packet
        for (int a = sa; a < sa + 12 && a < NB; a++)
            chk(fmem[a] == pm[a], {tag, " R7 array byte"}, fmem[a], pm[a]);
    endtask

    initial begin
        clear_array();
        repeat (3) @(negedge clk);
        // R1
        chk(busy == 0 && done == 0 && fz_wr == 0 && fz_rd == 0, "R1 reset", busy, 0);
        @(negedge clk); rst = 1'b0;
        chk(busy == 0 && done == 0 && fz_wr == 0 && fz_rd == 0, "R1 post-reset", busy, 0);

        // R2 R7 one-byte header, all words
        run("t1", 0, 7'd5, 4'h0, 64'h8877_6655_4433_2211, 0);
        chk(fmem[0] == 8'h50, "t1 R2 header", fmem[0], 8'h50);
        // R3 two-byte header, words 1 and 3
        run("t2", 20, 7'h2A, 4'b0101, 64'hDEAD_BEEF_CAFE_F00D, 0);
        chk(fmem[20] == 8'h4F && fmem[21] == 8'h55, "t2 R3 header", {fmem[20], fmem[21]}, 16'h4F55);
        chk(fmem[22] == 8'hFE && fmem[24] == 8'hAD, "t2 R7 order", {fmem[22], fmem[24]}, 16'hFEAD);
        // R12 empty mask
        run("t3", 40, 7'd3, 4'hF, 64'h0, 0);
        // R2/R3 boundary: section 15 and 16
        run("t4", 50, 7'd15, 4'b1110, 64'h0000_0000_0000_A55A, 0);
        chk(fmem[50] == 8'hFE, "t4 R2 sec15", fmem[50], 8'hFE);
        run("t5", 60, 7'd16, 4'b1101, 64'h0000_0000_3C3C_0000, 0);
        chk(fmem[60] == 8'h0F && fmem[61] == 8'h2D, "t5 R3 sec16", {fmem[60], fmem[61]}, 16'h0F2D);
        // R5 retries within the budget
        fdrop[80] = 3;
        run("t6", 80, 7'd2, 4'b0011, 64'h1234_5678_0000_0000, 0);
        // R5 shared budget exhausted across two header bytes
        fdrop[100] = 2; fdrop[101] = 2;
        run("t7", 100, 7'h55, 4'b0000, 64'hFFFF_0000_1111_2222, 0);
        chk(fmem[102] == 8'hFF, "t7 R5 no data", fmem[102], 8'hFF);
        // R6 header read-back corrupted
        fmem[120] = 8'h00;
        run("t8", 120, 7'd6, 4'b0000, 64'h0102_0304_0506_0708, 0);
        chk(fmem[121] == 8'hFF, "t8 R6 no data", fmem[121], 8'hFF);
        // R8 data mismatch on word 1 (pre-burned byte), no data retry
        fmem[143] = 8'h0F;
        run("t9", 140, 7'd9, 4'b0000, 64'h7766_5544_33A5_1100, 0);
        // R8 dropped data write leaves erased byte: word 2 bad
        fdrop[165] = 1;
        run("t10", 160, 7'd1, 4'b0000, 64'h0807_0605_0403_0201, 0);
        // R11 start while busy ignored
        run("t11", 180, 7'd12, 4'b1010, 64'h0000_9999_0000_7777, 4);
        chk(fmem[380] == 8'hFF, "t11 R11 ignored", fmem[380], 8'hFF);

        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule